// File: doc/BRIEF.md
# Fuse-Backed Configuration Register Bank

This block keeps a small set of configuration bytes. Each byte exists twice: once in a one-time-programmable fuse copy that survives power cycles, and once in a volatile register copy that software can rewrite at will. A select bit per byte decides which copy drives the live configuration output and which copy a bus read returns. The same bit also marks the byte as a target when a fuse-programming run is started. Switching a select bit takes effect on the very next cycle, so software can try a setting in the register copy and then burn it.

A command byte at address 4 steers the bank. It holds the select bits and a switches-off flag. It also accepts three self-clearing actions: start fuse programming, clear the fault flag, and soft reset. Programming ORs each selected register byte into its fuse byte, so fuse bits only ever go from 0 to 1. A sticky fault flag is raised when programming is requested while the programming supply is reported low, or while the lock fuse (bit 6 of byte 2) is already blown. In either case no fuse bit changes. A build parameter gives a fixed variant whose select bits are held at zero, so its configuration always comes from the fuses.

The host side is a plain byte-addressed port. A read returns its data one cycle after the read strobe.

Top module: `cfg_shadow_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, the select bits, the switches-off flag, the fault flag, the register copies and the read data register are cleared. After that edge, `cfg_out` equals the fuse contents (`OTP_INIT` when nothing has been programmed).
- R2: A write to address 0, 1 or 2 stores the byte in that register copy. A read strobe at clock edge N puts the addressed value on `bus_rdata` after edge N. Addresses 3, 5, 6 and 7 read as 0.
- R3: For each byte i, when select bit i is 0, both `cfg_out[8i+7:8i]` and a read of address i give the fuse copy. When the bit is 1, both give the register copy. A write to the command byte changes this from the cycle after that write.
- R4: A read of address 4 returns bit 6 = fault flag, bit 4 = switches-off, and bits 2:0 = select bits for bytes 2..0. Bits 7, 5 and 3 always read 0.
- R5: Writing the command byte with bit 7 set, bit 5 clear, the supply OK and the lock fuse clear ORs each register copy into its fuse copy. Only the bytes whose select bit is set in that same written byte are affected. Fuse bits never go from 1 to 0.
- R6: A programming request made while `vpp_ok` is low sets the fault flag and changes no fuse bit.
- R7: A programming request made while fuse byte 2 bit 6 is 1 sets the fault flag and changes no fuse bit.
- R8: Writing the command byte with bit 6 set clears the fault flag. If the same write also makes a programming request that fails, the flag ends up set.
- R9: Writing the command byte with bit 5 set clears the select bits, the switches-off flag, the fault flag and the read data register, and ignores every other bit of that write. Register and fuse copies keep their contents.
- R10: While `shdn` is high at a clock edge, the select bits, the switches-off flag and the fault flag are cleared, and command writes have no effect.
- R11: With `FORCE_OTP` = 1, the select bits stay 0 whatever is written, so `cfg_out` always shows the fuse copies and the command byte reads 0 in bits 2:0.
- R12: `sw_off` follows command bit 4 from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| shdn | input | 1 | Shutdown; clears the command state |
| vpp_ok | input | 1 | Programming supply is high enough |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one cycle after the strobe |
| cfg_out | output | NUM_CFG*8 | Live configuration, byte i at bits 8i+7:8i |
| sw_off | output | 1 | Switches-off command |
| prog_fault | output | 1 | Sticky programming fault |

## Verification
Two actions can land on the same command write: clearing the fault flag and a programming request that fails. They are provoked together by writing 0xC2 with the supply low. The flag must then read set, because the new failure outranks the clear. A soft reset combined with a programming request and new select bits is provoked the same way. It must leave the fuses untouched and the select bits clear. Random traffic mixes these with reads of the same byte in the same cycle. Each result is judged against a bench model that applies the rules in priority order.

// File: rtl/cfg_bank_pkg.sv
// Shared constants for the fuse-backed configuration bank.
// Assumes an 8-bit command byte with the bit positions listed here.
package cfg_bank_pkg;
    localparam int BYTE_W    = 8;
    localparam int CMD_PROG  = 7;   // start fuse programming (pulse)
    localparam int CMD_FAULT = 6;   // clear fault on write, fault on read
    localparam int CMD_SRST  = 5;   // soft reset (pulse)
    localparam int CMD_SWOFF = 4;   // switches-off flag

    typedef struct packed {
        logic prog;
        logic clr_fault;
        logic srst;
        logic swoff;
    } cmd_req_t;
endpackage

// File: rtl/cfg_cmd_ctrl.sv
// Command byte state: select bits, switches-off and sticky fault.
// Decodes the self-clearing actions and issues a one-cycle program enable.
// Assumes shdn and rst_n outrank bus writes; soft reset outranks all other bits.
module cfg_cmd_ctrl
    import cfg_bank_pkg::*;
#(
    parameter int NUM_SEL   = 3,
    parameter bit FORCE_OTP = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shdn,
    input  logic               cmd_wr,
    input  logic [BYTE_W-1:0]  cmd_wdata,
    input  logic               lock,
    input  logic               vpp_ok,
    output logic [NUM_SEL-1:0] sel_q,
    output logic               swoff_q,
    output logic               fault_q,
    output logic               prog_en,
    output logic [NUM_SEL-1:0] prog_mask,
    output logic               soft_rst
);
    cmd_req_t           req;
    logic               wr_ok;
    logic               prog_bad;
    logic [NUM_SEL-1:0] new_sel;

    // Split the written byte into its action bits.
    always_comb begin
        req.prog      = cmd_wdata[CMD_PROG];
        req.clr_fault = cmd_wdata[CMD_FAULT];
        req.srst      = cmd_wdata[CMD_SRST];
        req.swoff     = cmd_wdata[CMD_SWOFF];
    end

    // Select bits taken from the write, or held at zero in the fixed variant.
    generate
        if (FORCE_OTP) begin : g_fixed
            assign new_sel = '0;
        end else begin : g_prog
            assign new_sel = cmd_wdata[NUM_SEL-1:0];
        end
    endgenerate

    // Qualify the write and classify the programming request.
    always_comb begin
        wr_ok     = rst_n && !shdn && cmd_wr;
        soft_rst  = wr_ok && req.srst;
        prog_bad  = wr_ok && !req.srst && req.prog && (lock || !vpp_ok);
        prog_en   = wr_ok && !req.srst && req.prog && !lock && vpp_ok;
        prog_mask = new_sel;
    end

    // Command state register, with a clear on reset, shutdown or soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || shdn || soft_rst) begin
            sel_q   <= '0;
            swoff_q <= 1'b0;
            fault_q <= 1'b0;
        end else if (wr_ok) begin
            sel_q   <= new_sel;
            swoff_q <= req.swoff;
            if (prog_bad)
                fault_q <= 1'b1;
            else if (req.clr_fault)
                fault_q <= 1'b0;
        end
    end
endmodule

// File: rtl/cfg_otp_array.sv
// Behavioural fuse array: one byte per entry, bits only ever set.
// Assumes the power-on contents are given by INIT and are not cleared by reset.
module cfg_otp_array
    import cfg_bank_pkg::*;
#(
    parameter int                        NUM_BYTES = 3,
    parameter logic [NUM_BYTES*8-1:0]    INIT      = '0
) (
    input  logic                         clk,
    input  logic                         prog_en,
    input  logic [NUM_BYTES-1:0]         prog_mask,
    input  logic [NUM_BYTES*BYTE_W-1:0]  src_flat,
    output logic [NUM_BYTES*BYTE_W-1:0]  otp_flat
);
    generate
        for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
            logic [BYTE_W-1:0] fuse_q = INIT[i*BYTE_W +: BYTE_W];

            // Burn the register byte into this fuse byte when it is targeted.
            always_ff @(posedge clk) begin
                if (prog_en && prog_mask[i])
                    fuse_q <= fuse_q | src_flat[i*BYTE_W +: BYTE_W];
            end

            assign otp_flat[i*BYTE_W +: BYTE_W] = fuse_q;
        end
    endgenerate
endmodule

// File: rtl/cfg_sel_mux.sv
// Per-byte steering between the fuse copy and the register copy.
// Assumes the select bit for byte i sits at index i.
module cfg_sel_mux
    import cfg_bank_pkg::*;
#(
    parameter int NUM_BYTES = 3
) (
    input  logic [NUM_BYTES-1:0]        sel,
    input  logic [NUM_BYTES*BYTE_W-1:0] otp_flat,
    input  logic [NUM_BYTES*BYTE_W-1:0] reg_flat,
    output logic [NUM_BYTES*BYTE_W-1:0] cfg_flat
);
    generate
        for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
            assign cfg_flat[i*BYTE_W +: BYTE_W] = sel[i] ? reg_flat[i*BYTE_W +: BYTE_W]
                                                         : otp_flat[i*BYTE_W +: BYTE_W];
        end
    endgenerate
endmodule

// File: rtl/cfg_shadow_bank.sv
// Top of the fuse-backed configuration bank: register copies, command byte,
// fuse array, steering and the registered read port.
// Assumes NUM_CFG <= 3 so the select bits fit in command bits 2:0.
module cfg_shadow_bank
    import cfg_bank_pkg::*;
#(
    parameter int                     NUM_CFG   = 3,
    parameter int                     ADDR_W    = 3,
    parameter int                     CMD_ADDR  = 4,
    parameter int                     LOCK_BYTE = 2,
    parameter int                     LOCK_BIT  = 6,
    parameter bit                     FORCE_OTP = 1'b0,
    parameter logic [NUM_CFG*8-1:0]   OTP_INIT  = 24'h00_35_A1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      shdn,
    input  logic                      vpp_ok,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [BYTE_W-1:0]         bus_wdata,
    output logic [BYTE_W-1:0]         bus_rdata,
    output logic [NUM_CFG*BYTE_W-1:0] cfg_out,
    output logic                      sw_off,
    output logic                      prog_fault
);
    localparam int FLAT_W = NUM_CFG * BYTE_W;

    logic [FLAT_W-1:0]  reg_flat;
    logic [FLAT_W-1:0]  otp_flat;
    logic [NUM_CFG-1:0] sel_q;
    logic [NUM_CFG-1:0] prog_mask;
    logic               prog_en;
    logic               soft_rst;
    logic               cmd_wr;
    logic [BYTE_W-1:0]  rd_mux;
    logic [BYTE_W-1:0]  rdata_q;

    assign cmd_wr = bus_wr && (bus_addr == ADDR_W'(CMD_ADDR));

    // Volatile register copies, one per configuration byte.
    generate
        for (genvar i = 0; i < NUM_CFG; i++) begin : g_reg
            logic [BYTE_W-1:0] byte_q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    byte_q <= '0;
                else if (bus_wr && bus_addr == ADDR_W'(i))
                    byte_q <= bus_wdata;
            end
            assign reg_flat[i*BYTE_W +: BYTE_W] = byte_q;
        end
    endgenerate

    cfg_cmd_ctrl #(.NUM_SEL(NUM_CFG), .FORCE_OTP(FORCE_OTP)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .shdn      (shdn),
        .cmd_wr    (cmd_wr),
        .cmd_wdata (bus_wdata),
        .lock      (otp_flat[LOCK_BYTE*BYTE_W + LOCK_BIT]),
        .vpp_ok    (vpp_ok),
        .sel_q     (sel_q),
        .swoff_q   (sw_off),
        .fault_q   (prog_fault),
        .prog_en   (prog_en),
        .prog_mask (prog_mask),
        .soft_rst  (soft_rst)
    );

    cfg_otp_array #(.NUM_BYTES(NUM_CFG), .INIT(OTP_INIT)) u_otp (
        .clk       (clk),
        .prog_en   (prog_en),
        .prog_mask (prog_mask),
        .src_flat  (reg_flat),
        .otp_flat  (otp_flat)
    );

    cfg_sel_mux #(.NUM_BYTES(NUM_CFG)) u_mux (
        .sel      (sel_q),
        .otp_flat (otp_flat),
        .reg_flat (reg_flat),
        .cfg_flat (cfg_out)
    );

    // Read data selection over configuration bytes and the command byte.
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_CFG; i++)
            if (bus_addr == ADDR_W'(i))
                rd_mux = cfg_out[i*BYTE_W +: BYTE_W];
        if (bus_addr == ADDR_W'(CMD_ADDR)) begin
            rd_mux[NUM_CFG-1:0] = sel_q;
            rd_mux[CMD_SWOFF]   = sw_off;
            rd_mux[CMD_FAULT]   = prog_fault;
        end
    end

    // Registered read port, cleared by power-up or soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            rdata_q <= '0;
        else if (bus_rd)
            rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/cfg_shadow_bank_chk.sv
// Property checker for cfg_shadow_bank, attached by bind below.
// Assumes it sees the top's ports and its select and fuse signals.
module cfg_shadow_bank_chk #(
    parameter int NUM_CFG   = 3,
    parameter int ADDR_W    = 3,
    parameter int CMD_ADDR  = 4,
    parameter bit FORCE_OTP = 1'b0
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 shdn,
    input logic                 vpp_ok,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [7:0]           bus_wdata,
    input logic                 sw_off,
    input logic                 prog_fault,
    input logic [NUM_CFG-1:0]   sel_q,
    input logic [NUM_CFG*8-1:0] otp_flat
);
    logic cw;
    assign cw = bus_wr && (bus_addr == ADDR_W'(CMD_ADDR)) && !shdn;

    AST_FUSE_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((otp_flat & $past(otp_flat)) == $past(otp_flat)));  // R5
    AST_LOW_SUPPLY_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (cw && !bus_wdata[5] && bus_wdata[7] && !vpp_ok) |=> prog_fault);  // R6
    AST_LOW_SUPPLY_NO_BURN: assert property (@(posedge clk) disable iff (!rst_n)
        (cw && !bus_wdata[5] && bus_wdata[7] && !vpp_ok) |=> $stable(otp_flat));  // R6
    AST_CLEAR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (cw && bus_wdata[6] && !bus_wdata[7]) |=> !prog_fault);  // R8
    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (cw && bus_wdata[5]) |=> (!prog_fault && !sw_off && sel_q == '0));  // R9
    AST_SHUTDOWN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        shdn |=> (!prog_fault && !sw_off && sel_q == '0));  // R10
    AST_FIXED_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (FORCE_OTP != 1'b0) |-> (sel_q == '0));  // R11
endmodule

bind cfg_shadow_bank cfg_shadow_bank_chk #(
    .NUM_CFG(NUM_CFG), .ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR), .FORCE_OTP(FORCE_OTP)
) i_chk (.*);

// File: tb/test_cfg_shadow_bank.sv
// Bench for cfg_shadow_bank: directed corner cases plus seeded random traffic,
// checked against a cycle model written from the requirements.
module test_cfg_shadow_bank;
    localparam logic [23:0] INIT = 24'h00_35_A1;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic       rst_n = 1'b0, shdn = 1'b0, vpp_ok = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [23:0] cfg_out;
    logic       sw_off, prog_fault;

    logic       f_wr = 1'b0, f_rd = 1'b0;
    logic [2:0] f_addr = '0;
    logic [7:0] f_wdata = '0, f_rdata;
    logic [23:0] f_cfg;
    logic       f_swoff, f_fault;

    cfg_shadow_bank #(.OTP_INIT(INIT)) i_cfg_shadow_bank (
        .clk(clk), .rst_n(rst_n), .shdn(shdn), .vpp_ok(vpp_ok),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cfg_out(cfg_out), .sw_off(sw_off), .prog_fault(prog_fault));

    cfg_shadow_bank #(.OTP_INIT(INIT), .FORCE_OTP(1'b1)) i_cfg_shadow_bank_fixed (
        .clk(clk), .rst_n(rst_n), .shdn(1'b0), .vpp_ok(1'b1),
        .bus_wr(f_wr), .bus_rd(f_rd), .bus_addr(f_addr), .bus_wdata(f_wdata),
        .bus_rdata(f_rdata), .cfg_out(f_cfg), .sw_off(f_swoff), .prog_fault(f_fault));

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    logic [7:0] m_otp [3];
    logic [7:0] m_reg [3];
    logic [2:0] m_sel;
    logic       m_swoff, m_fault;
    logic [7:0] m_rdata;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_cfg();
        for (int i = 0; i < 3; i++)
            exp_cfg[i*8 +: 8] = m_sel[i] ? m_reg[i] : m_otp[i];
    endfunction

    function automatic logic [7:0] exp_read(input logic [2:0] a);
        logic [23:0] c = exp_cfg();
        if (a < 3) return c[a*8 +: 8];
        if (a == 3'd4) return {1'b0, m_fault, 1'b0, m_swoff, 1'b0, m_sel};
        return 8'h00;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 3; i++) m_reg[i] = '0;
        m_sel = '0; m_swoff = 1'b0; m_fault = 1'b0; m_rdata = '0;
    endtask

    // Apply one clock of model behaviour for the inputs seen at this edge.
    task automatic model_edge();
        logic lock = m_otp[2][6];
        logic [7:0] rd_next = bus_rd ? exp_read(bus_addr) : m_rdata;
        if (!rst_n) begin model_reset(); return; end
        if (shdn) begin
            m_sel = '0; m_swoff = 1'b0; m_fault = 1'b0;
        end else if (bus_wr && bus_addr == 3'd4) begin
            if (bus_wdata[5]) begin
                m_sel = '0; m_swoff = 1'b0; m_fault = 1'b0; rd_next = '0;
            end else begin
                m_sel = bus_wdata[2:0]; m_swoff = bus_wdata[4];
                if (bus_wdata[7] && (lock || !vpp_ok)) m_fault = 1'b1;
                else if (bus_wdata[6]) m_fault = 1'b0;
                if (bus_wdata[7] && !lock && vpp_ok)
                    for (int i = 0; i < 3; i++)
                        if (bus_wdata[i]) m_otp[i] = m_otp[i] | m_reg[i];
            end
        end
        if (bus_wr && bus_addr < 3) m_reg[bus_addr] = bus_wdata;
        m_rdata = rd_next;
    endtask

    task automatic step(input logic w, input logic [2:0] a, input logic [7:0] d,
                        input logic r, input logic sd, input logic vp);
        bus_wr = w; bus_addr = a; bus_wdata = d; bus_rd = r; shdn = sd; vpp_ok = vp;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; shdn = 1'b0;
        chk("R2/R4 rdata", bus_rdata, m_rdata);
        chk("R3 cfg_out", cfg_out, exp_cfg());
        chk("R12 sw_off", sw_off, m_swoff);
        chk("R6/R8 fault", prog_fault, m_fault);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic vp);
        step(1'b1, a, d, 1'b0, 1'b0, vp);
    endtask

    task automatic rd(input logic [2:0] a);
        step(1'b0, a, 8'h00, 1'b1, 1'b0, 1'b1);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) m_otp[i] = INIT[i*8 +: 8];
        model_reset();
        void'($urandom(32'd2024));
        @(negedge clk);
        step(1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1);
        step(1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1);
        // R1: reset state
        chk("R1 rdata", bus_rdata, 8'h00);
        chk("R1 cfg_out", cfg_out, INIT);
        chk("R1 flags", {sw_off, prog_fault}, 2'b00);
        rst_n = 1'b1;

        wr(3'd0, 8'h5C, 1'b1);
        rd(3'd0);
        chk("R3 fuse copy read", bus_rdata, 8'hA1);
        wr(3'd4, 8'h11, 1'b1);
        chk("R12 sw_off set", sw_off, 1'b1);
        chk("R3 register copy live", cfg_out[7:0], 8'h5C);
        rd(3'd0);
        chk("R2 register read", bus_rdata, 8'h5C);
        rd(3'd4);
        chk("R4 command read", bus_rdata, 8'h11);
        rd(3'd6);
        chk("R2 unused address", bus_rdata, 8'h00);

        wr(3'd4, 8'h81, 1'b1);           // burn byte 0
        wr(3'd4, 8'h00, 1'b1);
        chk("R5 burned byte", cfg_out[7:0], 8'hFD);
        chk("R5 unselected byte", cfg_out[15:8], 8'h35);

        wr(3'd1, 8'h0A, 1'b1);
        wr(3'd4, 8'h82, 1'b0);           // low supply
        chk("R6 fault set", prog_fault, 1'b1);
        rd(3'd4);
        chk("R4 fault bit", bus_rdata, 8'h42);
        wr(3'd4, 8'h00, 1'b1);
        chk("R6 fuse unchanged", cfg_out[15:8], 8'h35);

        wr(3'd4, 8'h40, 1'b1);
        chk("R8 clear fault", prog_fault, 1'b0);
        wr(3'd4, 8'hC2, 1'b0);
        chk("R8 failure beats clear", prog_fault, 1'b1);

        rd(3'd1);
        wr(3'd4, 8'hB7, 1'b1);           // soft reset with other bits
        chk("R9 cleared", {sw_off, prog_fault, bus_rdata}, 10'h000);
        chk("R9 fuse untouched", cfg_out, {8'h00, 8'h35, 8'hFD});
        wr(3'd4, 8'h01, 1'b1);
        chk("R9 register kept", cfg_out[7:0], 8'h5C);

        wr(3'd4, 8'h13, 1'b1);
        step(1'b1, 3'd4, 8'h17, 1'b0, 1'b1, 1'b1);   // shutdown with a write
        chk("R10 shutdown", {sw_off, prog_fault}, 2'b00);
        chk("R10 fuse config", cfg_out, {8'h00, 8'h35, 8'hFD});

        for (int k = 0; k < 1500; k++) begin
            logic [2:0] a = 3'($urandom_range(0, 7));
            logic [7:0] d = 8'($urandom);
            int op = $urandom_range(0, 9);
            logic vp = ($urandom_range(0, 3) != 0);
            if (a == 3'd2) d[6] = 1'b0;                     // keep the lock clear
            if (a == 3'd4 && $urandom_range(0, 3) != 0) d[7] = 1'b0;
            if (a == 3'd4 && $urandom_range(0, 7) != 0) d[5] = 1'b0;
            if (op < 4)       step(1'b1, a, d, 1'b0, 1'b0, vp);
            else if (op < 8)  step(1'b0, a, d, 1'b1, 1'b0, vp);
            else if (op < 9)  step(1'b1, a, d, 1'b1, 1'b0, vp);
            else              step(1'b0, a, d, 1'b0, ($urandom_range(0, 3) == 0), vp);
        end

        wr(3'd4, 8'h40, 1'b1);
        wr(3'd2, 8'h40, 1'b1);
        wr(3'd4, 8'h84, 1'b1);           // burn the lock
        wr(3'd0, 8'h02, 1'b1);
        wr(3'd4, 8'h81, 1'b1);
        chk("R7 lock fault", prog_fault, 1'b1);
        wr(3'd4, 8'h00, 1'b1);
        chk("R7 fuse unchanged", cfg_out[7:0], m_otp[0]);

        f_wr = 1'b1; f_addr = 3'd4; f_wdata = 8'h17;
        @(negedge clk);
        f_wr = 1'b0; f_rd = 1'b1;
        chk("R11 fixed cfg", f_cfg, INIT);
        @(negedge clk);
        f_rd = 1'b0;
        chk("R11 fixed select", f_rdata, 8'h10);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule